// File: doc/BRIEF.md
# Share-Weighted Round-Robin Arbiter for a Shared Slave Port

This block lets four memory-mapped masters share one slave port. Each master carries a share value: the number of transfers it may complete in a row once it holds the grant. When the holder has used its share, or drops its request, the grant moves to the next requesting master in rotating order. A master that is not requesting is skipped in the same cycle, so no cycle is lost.

The granted master's read, write, address and write data are steered onto the slave port. Read data coming back is delivered only to the granted master; every other master sees zero. A slave-side wait request holds the current transfer for as many cycles as it stays high. Those held cycles are not counted against the share. Requesting masters that do not hold the grant are told to wait. The slave port has a floor on the share: any smaller value, including zero, is raised to that floor.

Top module: `share_arbiter`

## Requirements
- R1: While other masters request, the holder completes at most its effective share of consecutive transfers. The grant then passes on. A transfer completes in a cycle where the granted master requests and `s_wait` is low.
- R2: When the holder stops requesting, the grant moves to another requesting master in that same cycle.
- R3: The effective share is max(raw share, MIN_SHARE), with a raw value of 0 taken as 1. With the defaults (MIN_SHARE=2), raw shares 0 and 1 both allow 2 transfers.
- R4: While `s_wait` is high, the slave-side signals and the grant hold. Those cycles do not advance the share count.
- R5: `s_read`, `s_write`, `s_addr` and `s_wdata` come from the granted master. With no request, `s_read` and `s_write` are 0.
- R6: `s_rdata` appears on the granted master's slice of `m_rdata`. Every other slice is zero.
- R7: The search runs in index order, starting one past the master that last held the grant, wrapping modulo 4. Non-requesting masters are skipped. A sole requester keeps the grant after its share runs out.
- R8: `m_wait[i]` is 1 when master i requests and is either not granted or granted while `s_wait` is high. Otherwise it is 0.
- R9: In cycles with no request, the grant holder and the share count are unchanged.
- R10: After reset, master 0 holds the grant and its share count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Per-master transfer request |
| m_read | input | NM | Per-master read strobe |
| m_write | input | NM | Per-master write strobe |
| m_addr | input | NM*AW | Per-master address, master i at bits [i*AW +: AW] |
| m_wdata | input | NM*DW | Per-master write data, master i at bits [i*DW +: DW] |
| m_share | input | NM*SHW | Per-master raw share, master i at bits [i*SHW +: SHW] |
| m_rdata | output | NM*DW | Per-master read data, zero unless granted |
| m_wait | output | NM | Per-master wait |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_addr | output | AW | Slave address |
| s_wdata | output | DW | Slave write data |
| s_rdata | input | DW | Slave read data |
| s_wait | input | 1 | Slave wait request |

## Verification
The bench targets four corner cases, each with a distinct failure signature:
- **Share exhaustion.** The grant must pass exactly on the last allowed transfer. An off-by-one counter lets a master take one transfer too many or too few.
- **Stretched transfers.** `s_wait` is held high in the middle of a tenure. A design that counts waiting cycles hands the grant over early.
- **Search order.** The bench drops the holder's request while others request, and rotates past non-requesting masters. A search that restarts at index 0, or inserts an idle cycle, grants the wrong master or none.
- **Floor and reset.** Raw shares of 0 and 1 are raised to the floor, and reset is reapplied mid-run. A design that skips the floor, or keeps stale counter state across reset, passes the grant early or late.

// File: rtl/share_arb_pkg.sv
package share_arb_pkg;

  // Effective share: zero reads as one, then the slave floor applies.
  function automatic int unsigned eff_share(input int unsigned raw,
                                            input int unsigned floor_v);
    int unsigned v;
    v = (raw == 0) ? 1 : raw;
    if (v < floor_v) v = floor_v;
    return v;
  endfunction

  // Index following idx in a ring of n masters.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NM = 4,
  parameter int IW = 2
) (
  input  logic [NM-1:0] req,
  input  logic [IW-1:0] base,
  output logic [IW-1:0] sel,
  output logic          any
);
  // Scan base+1 .. base+NM (wrapping); the first requester found wins.
  always_comb begin
    sel = base;
    any = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      int unsigned idx;
      idx = (int'(base) + k) % NM;
      if (!any && req[idx]) begin
        sel = IW'(idx);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure
  import share_arb_pkg::*;
#(
  parameter int NM        = 4,
  parameter int SHW       = 4,
  parameter int MIN_SHARE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          m_req,
  input  logic [NM*SHW-1:0]      m_share,
  input  logic                   s_wait,
  output logic [$clog2(NM)-1:0]  gnt,
  output logic                   gnt_valid,
  output logic                   xfer_done
);
  localparam int IW = $clog2(NM);
  localparam int CW = SHW + 1;

  logic [IW-1:0] g_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] pick_sel;
  logic          any_req;
  logic [CW-1:0] cur_cnt;
  logic          exhaust;
  logic [IW-1:0] nxt_idx;
  int unsigned   cur_share;

  arb_pick #(.NM(NM), .IW(IW)) u_pick (
    .req  (m_req),
    .base (g_q),
    .sel  (pick_sel),
    .any  (any_req)
  );

  always_comb begin
    gnt       = m_req[g_q] ? g_q : pick_sel;
    gnt_valid = any_req;
    cur_cnt   = (gnt == g_q) ? cnt_q : '0;
    cur_share = eff_share(int'(m_share[gnt*SHW +: SHW]), MIN_SHARE);
    xfer_done = any_req && !s_wait;
    exhaust   = xfer_done && ((int'(cur_cnt) + 1) >= int'(cur_share));
    nxt_idx   = IW'(ring_next(int'(gnt), NM));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q   <= '0;
      cnt_q <= '0;
    end else if (any_req) begin
      g_q   <= exhaust ? nxt_idx : gnt;
      cnt_q <= exhaust ? '0 : cur_cnt + CW'(xfer_done);
    end
  end

  AST_CNT_BELOW_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < int'(eff_share(int'(m_share[g_q*SHW +: SHW]), MIN_SHARE))); // R1
  AST_WAIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wait && m_req[g_q]) |=> (cnt_q == $past(cnt_q) && g_q == $past(g_q))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req == '0) |=> ($stable(g_q) && $stable(cnt_q))); // R9
  AST_GRANT_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_req) |-> m_req[gnt]); // R7
endmodule

// File: rtl/arb_route.sv
module arb_route #(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(NM)-1:0] gnt,
  input  logic                  gnt_valid,
  input  logic [NM-1:0]         m_req,
  input  logic [NM-1:0]         m_read,
  input  logic [NM-1:0]         m_write,
  input  logic [NM*AW-1:0]      m_addr,
  input  logic [NM*DW-1:0]      m_wdata,
  output logic [NM*DW-1:0]      m_rdata,
  output logic [NM-1:0]         m_wait,
  output logic                  s_read,
  output logic                  s_write,
  output logic [AW-1:0]         s_addr,
  output logic [DW-1:0]         s_wdata,
  input  logic [DW-1:0]         s_rdata,
  input  logic                  s_wait
);
  localparam int IW = $clog2(NM);

  always_comb begin
    s_read  = 1'b0;
    s_write = 1'b0;
    s_addr  = '0;
    s_wdata = '0;
    if (gnt_valid) begin
      s_read  = m_read[gnt];
      s_write = m_write[gnt];
      s_addr  = m_addr[gnt*AW +: AW];
      s_wdata = m_wdata[gnt*DW +: DW];
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_port
    logic owns;
    assign owns                 = gnt_valid && (gnt == IW'(i));
    assign m_rdata[i*DW +: DW]  = owns ? s_rdata : '0;
    assign m_wait[i]            = m_req[i] && (!owns || s_wait);
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_req & ~m_wait) <= 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req == '0) |-> (!s_read && !s_write)); // R5
  AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wait && gnt_valid && $stable(m_req) && $stable(m_addr)) |=> $stable(s_addr)); // R4
endmodule

// File: rtl/share_arbiter.sv
module share_arbiter #(
  parameter int NM        = 4,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SHW       = 4,
  parameter int MIN_SHARE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NM-1:0]      m_req,
  input  logic [NM-1:0]      m_read,
  input  logic [NM-1:0]      m_write,
  input  logic [NM*AW-1:0]   m_addr,
  input  logic [NM*DW-1:0]   m_wdata,
  input  logic [NM*SHW-1:0]  m_share,
  output logic [NM*DW-1:0]   m_rdata,
  output logic [NM-1:0]      m_wait,
  output logic               s_read,
  output logic               s_write,
  output logic [AW-1:0]      s_addr,
  output logic [DW-1:0]      s_wdata,
  input  logic [DW-1:0]      s_rdata,
  input  logic               s_wait
);
  localparam int IW = $clog2(NM);

  logic [IW-1:0] gnt;
  logic          gnt_valid;
  logic          xfer_done;

  arb_tenure #(.NM(NM), .SHW(SHW), .MIN_SHARE(MIN_SHARE)) u_tenure (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_req     (m_req),
    .m_share   (m_share),
    .s_wait    (s_wait),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .xfer_done (xfer_done)
  );

  arb_route #(.NM(NM), .AW(AW), .DW(DW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .m_req     (m_req),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_rdata   (m_rdata),
    .m_wait    (m_wait),
    .s_read    (s_read),
    .s_write   (s_write),
    .s_addr    (s_addr),
    .s_wdata   (s_wdata),
    .s_rdata   (s_rdata),
    .s_wait    (s_wait)
  );

  AST_DONE_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($countones(m_req & ~m_wait) == 1)); // R1
endmodule

// File: tb/share_arbiter_bench.sv
module share_arbiter_bench;
  localparam int NM = 4, AW = 16, DW = 32, SHW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NM-1:0]     m_req = '0, m_read, m_write, m_wait;
  logic [NM*AW-1:0]  m_addr = '0;
  logic [NM*DW-1:0]  m_wdata, m_rdata;
  logic [NM*SHW-1:0] m_share;
  logic              s_read, s_write, s_wait = 1'b0;
  logic [AW-1:0]     s_addr;
  logic [DW-1:0]     s_wdata, s_rdata;

  assign s_rdata = {16'h5A5A, s_addr};

  share_arbiter u_share_arbiter (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_read(m_read), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_share(m_share), .m_rdata(m_rdata),
    .m_wait(m_wait), .s_read(s_read), .s_write(s_write), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_wait(s_wait)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Each entry: {request mask m3..m0, s_wait, expected granted master (4 = none)}.
  // Shares m0=3, m1=0 (floor 2), m2=1 (floor 2), m3=4.
  localparam logic [7:0] VEC [16] = '{
    {4'b1111, 1'b0, 3'd0},  // R10 reset holder
    {4'b1111, 1'b0, 3'd0},
    {4'b1111, 1'b1, 3'd0},  // R4 stretch, not counted
    {4'b1111, 1'b0, 3'd0},  // R1 third transfer ends share
    {4'b1111, 1'b0, 3'd1},  // R7 next in ring
    {4'b1111, 1'b0, 3'd1},  // R3 raw 0 allows 2
    {4'b1010, 1'b0, 3'd3},  // R7 skip idle m2
    {4'b0000, 1'b0, 3'd4},  // R9 idle
    {4'b1000, 1'b0, 3'd3},  // R9 count kept
    {4'b1001, 1'b0, 3'd3},
    {4'b1001, 1'b0, 3'd3},  // R1 share 4 used
    {4'b1001, 1'b0, 3'd0},
    {4'b1000, 1'b0, 3'd3},  // R2 holder drops
    {4'b0100, 1'b0, 3'd2},  // R2
    {4'b0100, 1'b0, 3'd2},  // R3 raw 1 allows 2
    {4'b0100, 1'b0, 3'd2}   // R7 sole requester keeps grant
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] mask, input logic w, input int expg,
                      input int n, input string tag);
    logic [3:0] ew;
    @(negedge clk);
    m_req  = mask;
    s_wait = w;
    for (int i = 0; i < NM; i++) m_addr[i*AW +: AW] = {8'(i), 8'(n)};
    #1;
    for (int i = 0; i < NM; i++) ew[i] = mask[i] && ((i != expg) || w);
    chk(m_wait == ew, $sformatf("R8 %s step %0d m_wait", tag, n), 64'(m_wait), 64'(ew));
    if (expg < NM) begin
      logic [AW-1:0] ea;
      ea = {8'(expg), 8'(n)};
      chk(s_addr == ea, $sformatf("R5 %s step %0d s_addr", tag, n), 64'(s_addr), 64'(ea));
      chk(s_write == expg[0] && s_read == !expg[0],
          $sformatf("R5 %s step %0d strobes", tag, n), 64'({s_read, s_write}),
          64'({!expg[0], expg[0]}));
      chk(s_wdata == (32'hA000_0000 | 32'(expg)),
          $sformatf("R5 %s step %0d s_wdata", tag, n), 64'(s_wdata),
          64'(32'hA000_0000 | 32'(expg)));
      for (int i = 0; i < NM; i++) begin
        logic [DW-1:0] er;
        er = (i == expg) ? {16'h5A5A, ea} : '0;
        chk(m_rdata[i*DW +: DW] == er, $sformatf("R6 %s step %0d rdata m%0d", tag, n, i),
            64'(m_rdata[i*DW +: DW]), 64'(er));
      end
    end else begin
      chk(!s_read && !s_write, $sformatf("R5 R9 %s step %0d idle", tag, n),
          64'({s_read, s_write}), 64'(0));
    end
  endtask

  initial begin
    m_read  = 4'b0101;
    m_write = 4'b1010;
    for (int i = 0; i < NM; i++) m_wdata[i*DW +: DW] = 32'hA000_0000 | 32'(i);
    m_share = {4'd4, 4'd1, 4'd0, 4'd3};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(m_wait == '0 && !s_read && !s_write, "R10 reset idle outputs",
        64'({m_wait, s_read, s_write}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 16; v++)
      step(VEC[v][7:4], VEC[v][3], int'(VEC[v][2:0]), v, "R1 R2 R3 R4 R7 table");

    // Reset mid-run: holder returns to m0 with a cleared count (R10).
    @(negedge clk);
    rst_n = 1'b0;
    m_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b1111, 1'b0, 0, 20, "R10 after reset");
    step(4'b1111, 1'b0, 0, 21, "R10 after reset");
    step(4'b1111, 1'b0, 0, 22, "R10 R1 share 3");
    step(4'b1111, 1'b0, 1, 23, "R10 R1 pass");
    // Long stretch on m1: many wait cycles still leave both of its transfers (R4).
    step(4'b1111, 1'b1, 1, 24, "R4 long wait");
    step(4'b1111, 1'b1, 1, 25, "R4 long wait");
    step(4'b1111, 1'b1, 1, 26, "R4 long wait");
    step(4'b1111, 1'b0, 1, 27, "R4 second transfer");
    step(4'b1111, 1'b0, 2, 28, "R4 R1 pass to m2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule